// File: doc/BRIEF.md
# PLL Configuration Register Bank

This block holds the complete set of control settings for one phase-locked loop and presents them both to the loop itself, as parallel field outputs, and to software, as four 32-bit words on a simple memory-mapped bus with address, write enable, write data and read data. The settings are the feedback divider, the reference divider, two cascaded post-dividers, a 24-bit fractional divider, a two-bit operating mode and a bit that chooses between integer and fractional synthesis. A read-only lock flag, taken from the loop through a small synchronizer, is merged into one of the words.

Three of the words are updated by masked writes. The upper half of the write data is a per-bit enable for the lower half, so any one field can be changed in a single bus write without reading the word first. The fractional word is the exception and takes a plain write of its divider field. Writes land on the clock edge that ends the write cycle. Reads are combinational from the stored state. Offsets outside the four words are ignored on write and return zero on read.

Top module: `pll_cfg_bank`

## Requirements
- R1: After reset the fields hold feedback divider 50, reference divider 1, both post-dividers 1, fraction 0, integer mode selected and operating mode 0 (slow). The words therefore read 0x00000032, 0x00001101, 0x00000000 (lock low) and 0x00000008.
- R2: Word offset 0x0 holds the feedback divider in bits 11:0. Offset 0x4 holds the reference divider in bits 5:0, post-divider one in bits 10:8 and post-divider two in bits 14:12. Offset 0x8 holds the fraction in bits 23:0 and lock in bit 31. Offset 0xC holds the mode in bits 9:8 (0 slow, 1 normal, 2 deep slow; 3 is stored as written) and the integer-mode bit in bit 3 (1 integer, 0 fractional). Each field appears unchanged on its output port.
- R3: In a write to offset 0x0, 0x4 or 0xC, stored bit i (0 to 15) takes write-data bit i only when write-data bit i+16 is 1. Otherwise it keeps its value.
- R4: A write to offset 0x8 loads write-data bits 23:0 into the fraction regardless of bits 31:16. Write-data bits 30:24 have no effect.
- R5: Bit 31 at offset 0x8 shows the lock input delayed by LOCK_SYNC clock edges (default 2). Writes never change it.
- R6: Reads of offsets 0x0, 0x4 and 0xC return zero in bits 31:16 and in every lower bit that holds no field.
- R7: Any address other than 0x0, 0x4, 0x8 or 0xC is unmapped, including unaligned addresses and addresses with any bit above bit 3 set. Writes to it change no field, and reads of it return zero.
- R8: A write becomes visible on the outputs and in read data after the rising edge at which write enable is sampled high, and not before that edge.
- R9: While write enable is low, no stored field changes, whatever the address and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_we | input | 1 | Write enable, sampled at the rising edge |
| bus_wdata | input | 32 | Write data, with the per-bit enables in bits 31:16 for masked words |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pll_lock_in | input | 1 | Lock indication from the loop, asynchronous |
| fb_div | output | 12 | Feedback divider |
| ref_div | output | 6 | Reference divider |
| post_div1 | output | 3 | First post-divider |
| post_div2 | output | 3 | Second post-divider |
| frac_div | output | 24 | Fractional divider |
| work_mode | output | 2 | Operating mode |
| int_mode | output | 1 | 1 = integer synthesis, 0 = fractional |

## Verification
The assertions assume that bus_addr, bus_we and bus_wdata are stable around the rising edge and carry no unknown values once reset is released. They also assume that reset is held from time zero. The bench drives every bus input only on the falling edge and sets all inputs to known values before the first edge. It changes pll_lock_in only on a falling edge, so the synchronizer delay can be counted exactly. The address sweep stays within the ADDR_W-bit space, so every unmapped case the decoder can see is covered.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned FRAC_W = 24;
    localparam int unsigned N_WORDS = 4;

    typedef enum logic [1:0] {
        WM_SLOW      = 2'd0,
        WM_NORMAL    = 2'd1,
        WM_DEEP_SLOW = 2'd2,
        WM_RESERVED  = 2'd3
    } work_mode_e;

    // Slot numbers follow the word offset (offset = slot * 4)
    localparam int unsigned SLOT_FB   = 0;
    localparam int unsigned SLOT_DIV  = 1;
    localparam int unsigned SLOT_FRAC = 2;
    localparam int unsigned SLOT_MODE = 3;

    // Implemented bits of each masked word
    localparam logic [HALF_W-1:0] FB_IMPL   = 16'h0FFF;
    localparam logic [HALF_W-1:0] DIV_IMPL  = 16'h773F;
    localparam logic [HALF_W-1:0] MODE_IMPL = 16'h0308;

    // Values after reset
    localparam logic [HALF_W-1:0] FB_RST   = 16'h0032;
    localparam logic [HALF_W-1:0] DIV_RST  = 16'h1101;
    localparam logic [HALF_W-1:0] MODE_RST = 16'h0008;
    localparam logic [FRAC_W-1:0] FRAC_RST = '0;

endpackage

// File: rtl/pllcfg_addr_dec.sv
module pllcfg_addr_dec #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]               addr,
    output logic [pllcfg_pkg::N_WORDS-1:0]  sel,
    output logic                            hit
);
    localparam int unsigned IDX_LO = 2;

    logic upper_zero;
    logic aligned;

    generate
        if (ADDR_W > 4) begin : g_upper
            assign upper_zero = (addr[ADDR_W-1:4] == '0);
        end else begin : g_no_upper
            assign upper_zero = 1'b1;
        end
    endgenerate

    assign aligned = (addr[IDX_LO-1:0] == '0);
    assign hit     = aligned && upper_zero;

    always_comb begin
        sel = '0;
        if (hit) begin
            sel[addr[IDX_LO+1:IDX_LO]] = 1'b1;
        end
    end
endmodule

// File: rtl/pllcfg_field_reg.sv
module pllcfg_field_reg #(
    parameter int unsigned   W    = 16,
    parameter logic [W-1:0]  IMPL = '1,
    parameter logic [W-1:0]  RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] wr_msk,
    output logic [W-1:0] q
);
    logic [W-1:0] eff_msk;
    logic [W-1:0] q_next;

    assign eff_msk = wr_msk & IMPL;

    always_comb begin
        q_next = q;
        if (wr_en) begin
            q_next = (q & ~eff_msk) | (wr_val & eff_msk);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST;
        end else begin
            q <= q_next;
        end
    end

    // R9: no write, no change
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));

    // R3: only enabled bits may move
    p_mask_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((q ^ $past(q)) & ~$past(wr_msk)) == '0));
endmodule

// File: rtl/pllcfg_lock_sync.sv
module pllcfg_lock_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_in};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= async_in;
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned LOCK_SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              pll_lock_in,
    output logic [11:0]       fb_div,
    output logic [5:0]        ref_div,
    output logic [2:0]        post_div1,
    output logic [2:0]        post_div2,
    output logic [23:0]       frac_div,
    output logic [1:0]        work_mode,
    output logic              int_mode
);
    import pllcfg_pkg::*;

    localparam int unsigned LOCK_POS = BUS_W - 1;

    logic [N_WORDS-1:0] sel;
    logic               hit;
    logic [HALF_W-1:0]  q_fb, q_div, q_mode;
    logic [FRAC_W-1:0]  q_frac;
    logic               lock_s;
    logic               unused_wbits;

    assign unused_wbits = ^bus_wdata[BUS_W-1:FRAC_W];

    pllcfg_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .hit  (hit)
    );

    pllcfg_field_reg #(.W(HALF_W), .IMPL(FB_IMPL), .RST(FB_RST)) u_fb (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we && sel[SLOT_FB]),
        .wr_val(bus_wdata[HALF_W-1:0]), .wr_msk(bus_wdata[BUS_W-1:HALF_W]),
        .q(q_fb)
    );

    pllcfg_field_reg #(.W(HALF_W), .IMPL(DIV_IMPL), .RST(DIV_RST)) u_div (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we && sel[SLOT_DIV]),
        .wr_val(bus_wdata[HALF_W-1:0]), .wr_msk(bus_wdata[BUS_W-1:HALF_W]),
        .q(q_div)
    );

    pllcfg_field_reg #(.W(FRAC_W), .IMPL('1), .RST(FRAC_RST)) u_frac (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we && sel[SLOT_FRAC]),
        .wr_val(bus_wdata[FRAC_W-1:0]), .wr_msk('1),
        .q(q_frac)
    );

    pllcfg_field_reg #(.W(HALF_W), .IMPL(MODE_IMPL), .RST(MODE_RST)) u_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we && sel[SLOT_MODE]),
        .wr_val(bus_wdata[HALF_W-1:0]), .wr_msk(bus_wdata[BUS_W-1:HALF_W]),
        .q(q_mode)
    );

    pllcfg_lock_sync #(.STAGES(LOCK_SYNC)) u_lock (
        .clk(clk), .rst_n(rst_n), .async_in(pll_lock_in), .sync_out(lock_s)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (1'b1)
            sel[SLOT_FB]:   bus_rdata[HALF_W-1:0] = q_fb;
            sel[SLOT_DIV]:  bus_rdata[HALF_W-1:0] = q_div;
            sel[SLOT_FRAC]: begin
                bus_rdata[FRAC_W-1:0] = q_frac;
                bus_rdata[LOCK_POS]   = lock_s;
            end
            sel[SLOT_MODE]: bus_rdata[HALF_W-1:0] = q_mode;
            default:        bus_rdata = '0;
        endcase
    end

    assign fb_div    = q_fb[11:0];
    assign ref_div   = q_div[5:0];
    assign post_div1 = q_div[10:8];
    assign post_div2 = q_div[14:12];
    assign frac_div  = q_frac;
    assign work_mode = q_mode[9:8];
    assign int_mode  = q_mode[3];

    // R7: unmapped writes leave every field alone
    p_unmapped_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !hit) |=> $stable({q_fb, q_div, q_frac, q_mode}));

    // R7: unmapped reads are zero
    p_unmapped_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_rdata == '0));

    // R6: masked words never show the upper half
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[SLOT_FB] || sel[SLOT_DIV] || sel[SLOT_MODE]) |-> (bus_rdata[31:16] == '0));

    // R4: plain load of the fraction
    p_frac_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel[SLOT_FRAC]) |=> (frac_div == $past(bus_wdata[FRAC_W-1:0])));
endmodule

// File: tb/pll_cfg_bank_bench.sv
module pll_cfg_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              pll_lock_in = 1'b0;
    logic [11:0]       fb_div;
    logic [5:0]        ref_div;
    logic [2:0]        post_div1, post_div2;
    logic [23:0]       frac_div;
    logic [1:0]        work_mode;
    logic              int_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Bench model of the stored words
    logic [15:0] m_fb   = 16'h0032;
    logic [15:0] m_div  = 16'h1101;
    logic [23:0] m_frac = 24'h0;
    logic [15:0] m_mode = 16'h0008;
    logic        m_lock = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_cfg_bank #(.ADDR_W(ADDR_W), .LOCK_SYNC(2)) u_pll_cfg_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_lock_in(pll_lock_in),
        .fb_div(fb_div), .ref_div(ref_div), .post_div1(post_div1),
        .post_div2(post_div2), .frac_div(frac_div), .work_mode(work_mode),
        .int_mode(int_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [15:0] apply_mask(input logic [15:0] old,
        input logic [31:0] w, input logic [15:0] impl);
        logic [15:0] m;
        m = w[31:16] & impl;
        return (old & ~m) | (w[15:0] & m);
    endfunction

    task automatic check_all(input string req);
        logic [31:0] r;
        bus_read(8'h00, r); check(req, r, {16'h0, m_fb});
        bus_read(8'h04, r); check(req, r, {16'h0, m_div});
        bus_read(8'h08, r); check(req, r, {m_lock, 7'h0, m_frac});
        bus_read(8'h0C, r); check(req, r, {16'h0, m_mode});
        check({req, " R2 ports"}, {fb_div, ref_div, post_div1, post_div2, work_mode, int_mode},
              {m_fb[11:0], m_div[5:0], m_div[10:8], m_div[14:12], m_mode[9:8], m_mode[3]});
        check({req, " R2 frac port"}, {8'h0, frac_div}, {8'h0, m_frac});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_all("R1 reset");

        // R3 / R6 masked sweeps over the three masked words
        for (int w = 0; w < 3; w++) begin
            for (int k = 0; k < 72; k++) begin
                logic [31:0] wd;
                logic [7:0]  a;
                if (k == 64)      wd = 32'hFFFF_FFFF;
                else if (k == 65) wd = 32'hFFFF_0000;
                else if (k == 66) wd = 32'h0000_FFFF;
                else begin
                    wd[31:16] = 16'(k * 16'h9E37) ^ 16'(k << 7);
                    wd[15:0]  = 16'(k * 16'h3B5D + 16'h1234);
                end
                case (w)
                    0: begin a = 8'h00; m_fb   = apply_mask(m_fb, wd, 16'h0FFF); end
                    1: begin a = 8'h04; m_div  = apply_mask(m_div, wd, 16'h773F); end
                    default: begin a = 8'h0C; m_mode = apply_mask(m_mode, wd, 16'h0308); end
                endcase
                bus_write(a, wd);
                bus_read(a, r);
                check("R3 R6 masked word", r, (w == 0) ? {16'h0, m_fb} :
                                               (w == 1) ? {16'h0, m_div} : {16'h0, m_mode});
            end
        end
        check_all("R3 after sweep");

        // R2 mode encodings
        for (int md = 0; md < 4; md++) begin
            bus_write(8'h0C, {16'h0300, 6'h0, 2'(md), 8'h0});
            m_mode[9:8] = 2'(md);
            check("R2 work mode", {30'h0, work_mode}, 32'(md));
        end
        bus_write(8'h0C, 32'h0300_0200);
        m_mode[9:8] = 2'd2;
        check("R2 deep slow", {30'h0, work_mode}, {30'h0, pllcfg_pkg::WM_DEEP_SLOW});
        bus_write(8'h0C, 32'h0008_0000);
        m_mode[3] = 1'b0;
        check("R2 fractional select", {31'h0, int_mode}, 32'h0);

        // R4 plain fraction writes
        for (int k = 0; k < 20; k++) begin
            logic [31:0] wd;
            wd = 32'(k * 32'h0913_5A77 + 32'h00C0_FFEE);
            if (k == 0) wd = 32'hFFFF_FFFF;
            if (k == 1) wd = 32'h0000_0000;
            bus_write(8'h08, wd);
            m_frac = wd[23:0];
            bus_read(8'h08, r);
            check("R4 fraction load", r, {m_lock, 7'h0, m_frac});
        end
        check_all("R4 others intact");

        // R5 lock synchronizer delay and read-only behaviour
        @(negedge clk);
        pll_lock_in = 1'b1;
        bus_read(8'h08, r); check("R5 lock before edge", {31'h0, r[31]}, 32'h0);
        @(negedge clk);
        bus_read(8'h08, r); check("R5 lock after 1 edge", {31'h0, r[31]}, 32'h0);
        @(negedge clk);
        bus_read(8'h08, r); check("R5 lock after 2 edges", {31'h0, r[31]}, 32'h1);
        m_lock = 1'b1;
        bus_write(8'h08, 32'h0000_0000);
        m_frac = 24'h0;
        bus_read(8'h08, r); check("R5 write keeps lock", r, 32'h8000_0000);
        @(negedge clk);
        pll_lock_in = 1'b0;
        bus_write(8'h08, 32'hFFAB_CDEF);
        m_frac = 24'hABCDEF;
        @(negedge clk);
        bus_read(8'h08, r); check("R5 lock low", r, 32'h00AB_CDEF);
        m_lock = 1'b0;

        // R8 write not visible before its edge
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 32'h0FFF_0A5A; bus_we = 1'b1;
        #1;
        check("R8 before edge", bus_rdata, {16'h0, m_fb});
        @(negedge clk);
        bus_we = 1'b0;
        m_fb = apply_mask(m_fb, 32'h0FFF_0A5A, 16'h0FFF);
        bus_read(8'h00, r); check("R8 after edge", r, {16'h0, m_fb});

        // R7 unmapped address sweep
        for (int a = 0; a < 256; a++) begin
            if (!(a == 0 || a == 4 || a == 8 || a == 12)) begin
                bus_write(8'(a), 32'hFFFF_FFFF);
                bus_read(8'(a), r);
                check("R7 unmapped read", r, 32'h0);
            end
        end
        check_all("R7 after unmapped writes");

        // R9 enable low on every word
        for (int a = 0; a < 16; a += 4) begin
            @(negedge clk);
            bus_addr = 8'(a); bus_wdata = 32'hFFFF_FFFF; bus_we = 1'b0;
            @(negedge clk);
        end
        check_all("R9 no write enable");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule